// File: doc/BRIEF.md
# Sliding 3x3 Rank Filter

This block takes a raster-order stream of 8-bit pixels, one per clock at most, and forms a 3x3 neighbourhood around every pixel position. The two rows above the incoming one are held in two line buffers. For each complete neighbourhood it sorts the nine values and returns one of them. The choice of value follows a mode code that travels with each pixel: the median for removing impulse noise, the minimum for erosion, or the maximum for dilation.

The stream has no frame marker. Rows and columns are counted from reset, and the row length is the parameter `IMG_W`. A neighbourhood that would reach past the left edge of a row, or into the rows before the first one, produces no output. The result comes out as a pixel with a valid strobe a fixed number of cycles after the pixel that completed the neighbourhood. Gaps in the input stream are allowed and simply pause the window.

Top module: `rank3_filter`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` and `out_pix` to 0. No output appears before the pixel at zero-based row 2, column 2 has been accepted.
- R2: Exactly one output is produced for each accepted pixel at zero-based row r >= 2 and column c >= 2, and none for any other pixel. Rows are IMG_W accepted pixels long and are counted from reset. The neighbourhood used is rows r-2..r by columns c-2..c.
- R3: The output for a pixel accepted on clock edge E is presented with `out_valid` high after edge E+10, independent of gaps in the input.
- R4: With mode code 0 the output is the median, which is the 5th smallest of the nine neighbourhood values.
- R5: With mode code 1 the output is the smallest of the nine neighbourhood values.
- R6: With mode code 2 the output is the largest of the nine neighbourhood values.
- R7: The mode is taken from `in_mode` together with the pixel that completes the neighbourhood, so it may change from pixel to pixel. Code 3 behaves as the median.
- R8: While `in_valid` is low, `in_pix` and `in_mode` are ignored: the window and the row and column counts do not advance, and no output is produced for that cycle.
- R9: Each of the two line buffers delays its row by IMG_W-3 accepted pixels. Together with the three window taps of a row, this aligns the three window rows on the same columns. An output is only produced once both buffers have been filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel strobe |
| in_pix | input | 8 | Input pixel, raster order |
| in_mode | input | 2 | Rank selection: 0 median, 1 minimum, 2 maximum, 3 median |
| out_valid | output | 1 | Output pixel strobe |
| out_pix | output | 8 | Selected rank of the neighbourhood |

## Verification
Every result is due after the tenth rising edge following the edge that accepted the pixel completing its neighbourhood. Gaps in the input do not change this count. When the bench drives a pixel, it records the cycle index at which the result must appear and the value computed from its own copy of the image. It samples the outputs on falling edges and requires each strobe to match the oldest pending entry in both value and cycle. After each scenario it drains the pipeline and compares the number of outputs with the count the border rule predicts. Any strobe for a border pixel or a paused cycle shows up as an unexpected output.

// File: rtl/rank3_pkg.sv
`timescale 1ns/1ps
package rank3_pkg;
    parameter int PIX_W = 8;

    localparam int WIN_DIM     = 3;
    localparam int N_TAPS      = WIN_DIM * WIN_DIM;
    localparam int SORT_STAGES = N_TAPS;          // odd-even transposition depth
    localparam int LATENCY     = SORT_STAGES + 1; // sort stages plus output register
    localparam int MID_IDX     = N_TAPS / 2;

    typedef logic [PIX_W-1:0] pix_t;
    typedef pix_t [N_TAPS-1:0] taps_t;

    typedef enum logic [1:0] {
        RANK_MED = 2'd0,
        RANK_MIN = 2'd1,
        RANK_MAX = 2'd2,
        RANK_ALT = 2'd3
    } rank_mode_e;

    typedef struct packed {
        logic       vld;
        rank_mode_e mode;
        taps_t      taps;
    } sort_word_t;

    // position in an ascending list that a mode selects
    function automatic int rank_index(rank_mode_e m);
        case (m)
            RANK_MIN: return 0;
            RANK_MAX: return N_TAPS - 1;
            default:  return MID_IDX;
        endcase
    endfunction

    function automatic pix_t pick_rank(taps_t t, rank_mode_e m);
        return t[rank_index(m)];
    endfunction
endpackage

// File: rtl/rank3_line_fifo.sv
`timescale 1ns/1ps
module rank3_line_fifo
    import rank3_pkg::*;
#(
    parameter int DEPTH = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  pix_t din,
    output pix_t dout,
    output logic full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FW = AW + 1;

    pix_t           mem [DEPTH];
    logic [AW-1:0]  slot;   // read and write position coincide in steady state
    logic [FW-1:0]  fill;

    // oldest entry is read before the same slot is overwritten
    assign dout = mem[slot];
    assign full = (fill == FW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
            fill <= '0;
        end else if (push) begin
            slot <= (slot == AW'(DEPTH - 1)) ? '0 : slot + AW'(1);
            if (!full) begin
                fill <= fill + FW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[slot] <= din;
        end
    end
endmodule

// File: rtl/rank3_window.sv
`timescale 1ns/1ps
module rank3_window
    import rank3_pkg::*;
#(
    parameter int IMG_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  pix_t       in_pix,
    input  rank_mode_e in_mode,
    output logic       win_valid,
    output rank_mode_e win_mode,
    output taps_t      win_taps,
    output logic       lines_full
);
    localparam int LINE_DEPTH = IMG_W - WIN_DIM;
    localparam int N_LINES    = WIN_DIM - 1;
    localparam int CW         = $clog2(IMG_W);
    localparam int RW         = $clog2(WIN_DIM);

    pix_t               tap_q   [WIN_DIM][WIN_DIM]; // [row][col], row 0 top, col 0 newest
    pix_t               row_in  [WIN_DIM];
    pix_t               line_out[N_LINES];
    logic [N_LINES-1:0] line_full;
    logic [CW-1:0]      col;
    logic [RW-1:0]      rows_seen;

    // bottom row takes the stream, upper rows take the line buffers
    assign row_in[WIN_DIM-1] = in_pix;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        rank3_line_fifo #(.DEPTH(LINE_DEPTH)) u_line (
            .clk  (clk),
            .rst  (rst),
            .push (in_valid),
            .din  (tap_q[g+1][WIN_DIM-1]),
            .dout (line_out[g]),
            .full (line_full[g])
        );
        assign row_in[g] = line_out[g];
    end

    assign lines_full = &line_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < WIN_DIM; r++) begin
                for (int c = 0; c < WIN_DIM; c++) begin
                    tap_q[r][c] <= '0;
                end
            end
        end else if (in_valid) begin
            for (int r = 0; r < WIN_DIM; r++) begin
                tap_q[r][0] <= row_in[r];
                for (int c = 1; c < WIN_DIM; c++) begin
                    tap_q[r][c] <= tap_q[r][c-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col       <= '0;
            rows_seen <= '0;
            win_valid <= 1'b0;
            win_mode  <= RANK_MED;
        end else begin
            win_valid <= in_valid && (rows_seen == RW'(WIN_DIM - 1))
                                  && (col >= CW'(WIN_DIM - 1));
            if (in_valid) begin
                win_mode <= in_mode;
                if (col == CW'(IMG_W - 1)) begin
                    col <= '0;
                    if (rows_seen != RW'(WIN_DIM - 1)) begin
                        rows_seen <= rows_seen + RW'(1);
                    end
                end else begin
                    col <= col + CW'(1);
                end
            end
        end
    end

    always_comb begin
        for (int r = 0; r < WIN_DIM; r++) begin
            for (int c = 0; c < WIN_DIM; c++) begin
                win_taps[r*WIN_DIM + c] = tap_q[r][c];
            end
        end
    end
endmodule

// File: rtl/rank3_sort_net.sv
`timescale 1ns/1ps
module rank3_sort_net
    import rank3_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sort_word_t word_i,
    output sort_word_t word_o
);
    sort_word_t chain [SORT_STAGES+1];

    assign chain[0] = word_i;

    for (genvar s = 0; s < SORT_STAGES; s++) begin : g_stage
        sort_word_t nxt;
        sort_word_t q;

        // compare-exchange on pairs whose lower index has the stage parity
        always_comb begin
            nxt = chain[s];
            for (int i = s % 2; i + 1 < N_TAPS; i += 2) begin
                if (chain[s].taps[i] > chain[s].taps[i+1]) begin
                    nxt.taps[i]   = chain[s].taps[i+1];
                    nxt.taps[i+1] = chain[s].taps[i];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else begin
                q <= nxt;
            end
        end

        assign chain[s+1] = q;
    end

    assign word_o = chain[SORT_STAGES];
endmodule

// File: rtl/rank3_filter.sv
`timescale 1ns/1ps
module rank3_filter
    import rank3_pkg::*;
#(
    parameter int IMG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    input  logic [1:0]       in_mode,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);
    logic       win_valid;
    rank_mode_e win_mode;
    taps_t      win_taps;
    logic       lines_full;
    sort_word_t srt_in;
    sort_word_t srt_out;

    rank3_window #(.IMG_W(IMG_W)) u_win (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_pix     (in_pix),
        .in_mode    (rank_mode_e'(in_mode)),
        .win_valid  (win_valid),
        .win_mode   (win_mode),
        .win_taps   (win_taps),
        .lines_full (lines_full)
    );

    assign srt_in = '{vld: win_valid, mode: win_mode, taps: win_taps};

    rank3_sort_net u_sort (
        .clk    (clk),
        .rst    (rst),
        .word_i (srt_in),
        .word_o (srt_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= srt_out.vld;
            if (srt_out.vld) begin
                out_pix <= pick_rank(srt_out.taps, srt_out.mode);
            end
        end
    end
endmodule

// File: rtl/rank3_filter_chk.sv
`timescale 1ns/1ps
module rank3_filter_chk
    import rank3_pkg::*;
#(
    parameter int IMG_W = 16
) (
    input logic  clk,
    input logic  rst,
    input logic  in_valid,
    input logic  win_valid,
    input logic  lines_full,
    input logic  out_valid,
    input logic  srt_vld,
    input taps_t srt_taps
);
    localparam int FIRST_CNT = 2 * IMG_W + WIN_DIM;
    localparam int AW        = $clog2(FIRST_CNT + 1) + 1;

    logic [AW-1:0] acc_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_cnt <= '0;
        end else if (in_valid && acc_cnt < AW'(FIRST_CNT)) begin
            acc_cnt <= acc_cnt + AW'(1);
        end
    end

    function automatic logic ascending(taps_t t);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i + 1 < N_TAPS; i++) begin
            if (t[i] > t[i+1]) ok = 1'b0;
        end
        return ok;
    endfunction

    // R2
    border_chk: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> acc_cnt >= AW'(FIRST_CNT));

    // R9
    lines_full_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> lines_full);

    // R8
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> $past(in_valid));

    // R4
    sort_order_chk: assert property (@(posedge clk) disable iff (rst)
        srt_vld |-> ascending(srt_taps));
endmodule

bind rank3_filter rank3_filter_chk #(.IMG_W(IMG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .win_valid  (win_valid),
    .lines_full (lines_full),
    .out_valid  (out_valid),
    .srt_vld    (srt_out.vld),
    .srt_taps   (srt_out.taps)
);

// File: tb/rank3_filter_tb.sv
`timescale 1ns/1ps
module rank3_filter_tb;
    localparam int W    = 16;
    localparam int LAT  = 10;
    localparam int MAXR = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_pix = '0;
    logic [1:0] in_mode = '0;
    logic       out_valid;
    logic [7:0] out_pix;

    always #10 clk = ~clk;

    rank3_filter #(.IMG_W(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_pix    (in_pix),
        .in_mode   (in_mode),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    typedef struct {
        int pix;
        int mode;
        int due;
    } exp_t;

    exp_t q[$];
    int   img [MAXR][W];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    int   outs_seen = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic int ref_rank(int r, int c, int mode);
        int v[9];
        int k = 0;
        int t;
        for (int dr = 0; dr < 3; dr++)
            for (int dc = 0; dc < 3; dc++) begin
                v[k] = img[r-dr][c-dc];
                k++;
            end
        for (int i = 0; i < 9; i++)
            for (int j = 0; j < 8 - i; j++)
                if (v[j] > v[j+1]) begin
                    t = v[j]; v[j] = v[j+1]; v[j+1] = t;
                end
        if (mode == 1) return v[0];
        if (mode == 2) return v[8];
        return v[4];
    endfunction

    function automatic string mode_tag(int mode);
        case (mode)
            1: return "R5";
            2: return "R6";
            3: return "R7";
            default: return "R4 R9";
        endcase
    endfunction

    // output monitor: value and due cycle against the oldest expectation
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            outs_seen++;
            if (q.size() == 0) begin
                check(1'b0, "R2", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(int'(out_pix) == e.pix, mode_tag(e.mode), "pixel value", int'(out_pix), e.pix);
                check(cyc == e.due, "R3", "output cycle", cyc, e.due);
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        q.delete();
        outs_seen = 0;
    endtask

    task automatic send(int r, int c, int pix, int mode);
        exp_t e;
        img[r][c] = pix;
        in_valid = 1'b1;
        in_pix   = 8'(pix);
        in_mode  = 2'(mode);
        if (r >= 2 && c >= 2) begin
            e.pix  = ref_rank(r, c, mode);
            e.mode = mode;
            e.due  = cyc + 1 + LAT;
            q.push_back(e);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            in_pix   = 8'(8'hA5 ^ (i * 29));
            in_mode  = 2'(i);
            @(negedge clk);
        end
    endtask

    function automatic int gen_pix(int pat, int r, int c);
        if (pat == 9) return ((r + c) % 2 == 1) ? 255 : ((r * c) % 3 == 0 ? 0 : 255);
        return ((r * 37 + c * 11 + pat * 53) ^ (r * c * 7)) & 255;
    endfunction

    task automatic drain(string rq, int exp_outs);
        repeat (LAT + 4) @(negedge clk);
        check(q.size() == 0, rq, "pending results after drain", q.size(), 0);
        check(outs_seen == exp_outs, rq, "output count", outs_seen, exp_outs);
    endtask

    // mode_sel >= 0 fixes the mode, -1 cycles through all four codes
    task automatic run_frame(int rows, int pat, int mode_sel, bit gaps);
        for (int r = 0; r < rows; r++)
            for (int c = 0; c < W; c++) begin
                send(r, c, gen_pix(pat, r, c), (mode_sel >= 0) ? mode_sel : ((r + 2 * c) % 4));
                if (gaps && (c % 5 == 3)) idle(1 + (c % 3));
            end
    endtask

    task automatic t_reset_quiet();
        do_reset();
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(out_pix == 8'd0, "R1", "out_pix after reset", int'(out_pix), 0);
        for (int r = 0; r < 2; r++)
            for (int c = 0; c < W; c++) send(r, c, gen_pix(1, r, c), 0);
        send(2, 0, 7, 0);
        send(2, 1, 9, 0);
        repeat (LAT + 2) @(negedge clk);
        check(outs_seen == 0, "R1", "outputs before row 2 column 2", outs_seen, 0);
        send(2, 2, 200, 0);
        drain("R1", 1);
    endtask

    task automatic t_median();
        do_reset();
        run_frame(6, 2, 0, 1'b0);
        drain("R2", 4 * (W - 2));
    endtask

    task automatic t_minimum();
        do_reset();
        run_frame(5, 3, 1, 1'b0);
        drain("R5", 3 * (W - 2));
    endtask

    task automatic t_maximum();
        do_reset();
        run_frame(5, 4, 2, 1'b0);
        drain("R6", 3 * (W - 2));
    endtask

    task automatic t_mixed_modes();
        do_reset();
        run_frame(6, 5, -1, 1'b0);
        drain("R7", 4 * (W - 2));
    endtask

    task automatic t_bubbles();
        do_reset();
        idle(3);
        run_frame(6, 6, -1, 1'b1);
        drain("R8", 4 * (W - 2));
    endtask

    task automatic t_extremes();
        do_reset();
        run_frame(7, 9, -1, 1'b1);
        drain("R2", 5 * (W - 2));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset_quiet();
        t_median();
        t_minimum();
        t_maximum();
        t_mixed_modes();
        t_bubbles();
        t_extremes();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule